// File: doc/BRIEF.md
# Lock-Step Stream Join

This block joins several parallel valid/ready streams into one output stream. Each output beat carries one word from every input lane, packed side by side. A beat moves only when every lane offers a word and the single downstream consumer accepts it. All producers therefore advance together, and no producer can run ahead of the others.

The block is pure combinational steering. It has no storage and no clock. The ready returned to a lane depends on downstream ready and on the valids of all the *other* lanes, never on the lane's own valid. This keeps a producer from advancing alone while it still lets every lane see ready in the cycle the join fires.

Every producer must present registered valid and ready signals. Otherwise the block can close a combinational loop. A parameter selects how the all-but-one AND is built:
- a flat prefix/suffix chain across all lanes, or
- a two-level tree, which is a join of joins over equal groups.

Both forms give the same handshake.

Top module: `lockstep_join`

## Requirements
- R1: `out_valid` is 1 exactly when every bit of `in_valid` is 1.
- R2: `in_ready[i]` is 1 exactly when `out_ready` is 1 and every `in_valid[j]` with j different from i is 1. A lane's own valid has no effect on its own ready.
- R3: `out_data[i*WIDTH +: WIDTH]` equals `in_data[i*WIDTH +: WIDTH]` for every lane i, unchanged, in every cycle.
- R4: When `out_ready` is 0, every bit of `in_ready` is 0, whatever the valids are.
- R5: For every lane i, `in_valid[i] & in_ready[i]` equals `out_valid & out_ready` in every cycle. As a result, all lanes complete the same number of transfers, in the same order.
- R6: When two or more lanes are invalid, every bit of `in_ready` is 0, whatever `out_ready` is.
- R7: With `GROUP` set to a divisor of `LANES` (grouped join of joins), every output equals that of the flat form (`GROUP` = 0) for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_data | input | LANES*WIDTH | Lane words; lane i occupies bits [i*WIDTH +: WIDTH] |
| in_valid | input | LANES | Per-lane valid |
| in_ready | output | LANES | Per-lane ready, qualified by the other lanes' valids |
| out_data | output | LANES*WIDTH | Concatenated payload, same lane positions as in_data |
| out_valid | output | 1 | Joined valid |
| out_ready | input | 1 | Downstream ready |

## Verification
Three kinds of valid pattern drive the join:
- Dense random valids with random downstream ready exercise frequent firing. They show that every lane's transfer count stays equal and that the lane payloads carry matching sequence numbers.
- Sparse valids keep most cycles at two or more invalid lanes. This separates correct all-ready-low behaviour from a design that leaks ready to a lane.
- Directed patterns cover several cases:
  - exactly one lane invalid, where only that lane may see ready;
  - all valid with ready low;
  - all valid with ready high.

These patterns distinguish qualification by the other lanes from a plain broadcast of downstream ready. A flat instance and a grouped instance receive identical stimulus, and both are compared with the same expected values.

// File: rtl/lsj_pkg.sv
package lsj_pkg;

  // Number of first-level groups for a grouped join; 0 selects the flat form.
  function automatic int unsigned lsj_group_count(input int unsigned lanes,
                                                  input int unsigned gsize);
    if (gsize == 0) return 1;
    return lanes / gsize;
  endfunction

  // Width of a lane-indexed bit vector holding one group.
  function automatic int unsigned lsj_group_width(input int unsigned lanes,
                                                  input int unsigned gsize);
    if (gsize == 0) return lanes;
    return gsize;
  endfunction

  // Bit offset of a lane word inside a packed payload.
  function automatic int unsigned lsj_lane_lsb(input int unsigned lane,
                                               input int unsigned width);
    return lane * width;
  endfunction

endpackage

// File: rtl/lsj_and_excl.sv
// AND of all bits plus, for each position, the AND of all other bits.
module lsj_and_excl #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] bits_in,
  output logic         all_set,
  output logic [N-1:0] others_set
);
  logic [N:0] pre_and;
  logic [N:0] suf_and;

  assign pre_and[0] = 1'b1;
  assign suf_and[N] = 1'b1;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign pre_and[k+1] = pre_and[k] & bits_in[k];
    assign suf_and[k]   = suf_and[k+1] & bits_in[k];
  end

  for (genvar i = 0; i < N; i++) begin : g_excl
    assign others_set[i] = pre_and[i] & suf_and[i+1];
  end

  assign all_set = pre_and[N];
endmodule

// File: rtl/lsj_ready_steer.sv
// Turns "other lanes valid" into per-lane ready and per-lane fire events.
module lsj_ready_steer #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] others_valid,
  input  logic [N-1:0] lane_valid,
  input  logic         down_ready,
  output logic [N-1:0] lane_ready,
  output logic [N-1:0] lane_fire
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    assign lane_ready[i] = others_valid[i] & down_ready;
    assign lane_fire[i]  = lane_valid[i] & lane_ready[i];
  end
endmodule

// File: rtl/lsj_data_pack.sv
// Places each lane word at its fixed slot of the joined payload.
module lsj_data_pack
  import lsj_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned TOTAL = N * WIDTH
) (
  input  logic [TOTAL-1:0] lanes_in,
  output logic [TOTAL-1:0] joined_out
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    localparam int unsigned LSB = lsj_lane_lsb(i, WIDTH);
    assign joined_out[LSB +: WIDTH] = lanes_in[LSB +: WIDTH];
  end
endmodule

// File: rtl/lockstep_join.sv
module lockstep_join
  import lsj_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned GROUP = 0,
  localparam int unsigned TOTAL = LANES * WIDTH
) (
  input  logic [TOTAL-1:0] in_data,
  input  logic [LANES-1:0] in_valid,
  output logic [LANES-1:0] in_ready,
  output logic [TOTAL-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  localparam int unsigned NGRP = lsj_group_count(LANES, GROUP);
  localparam int unsigned GW   = lsj_group_width(LANES, GROUP);

  logic [LANES-1:0] others_valid;
  logic             all_valid;
  logic [LANES-1:0] lane_fire;
  logic             join_fire;

  if (GROUP == 0) begin : g_flat
    lsj_and_excl #(.N(LANES)) u_excl (
      .bits_in    (in_valid),
      .all_set    (all_valid),
      .others_set (others_valid)
    );
  end else begin : g_tree
    logic [NGRP-1:0] grp_all;
    logic [NGRP-1:0] grp_others;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic [GW-1:0] in_grp_others;
      logic          in_grp_all;

      lsj_and_excl #(.N(GW)) u_inner (
        .bits_in    (in_valid[g*GW +: GW]),
        .all_set    (in_grp_all),
        .others_set (in_grp_others)
      );

      assign grp_all[g] = in_grp_all;

      for (genvar k = 0; k < GW; k++) begin : g_lane
        assign others_valid[g*GW + k] = in_grp_others[k] & grp_others[g];
      end
    end

    lsj_and_excl #(.N(NGRP)) u_outer (
      .bits_in    (grp_all),
      .all_set    (all_valid),
      .others_set (grp_others)
    );
  end

  lsj_ready_steer #(.N(LANES)) u_steer (
    .others_valid (others_valid),
    .lane_valid   (in_valid),
    .down_ready   (out_ready),
    .lane_ready   (in_ready),
    .lane_fire    (lane_fire)
  );

  lsj_data_pack #(.N(LANES), .WIDTH(WIDTH)) u_pack (
    .lanes_in   (in_data),
    .joined_out (out_data)
  );

  assign out_valid = all_valid;
  assign join_fire = out_valid & out_ready;
endmodule

// File: rtl/lsj_checker.sv
module lsj_checker #(
  parameter int unsigned LANES = 4
) (
  input logic [LANES-1:0] in_valid,
  input logic [LANES-1:0] in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LANES-1:0] lane_fire,
  input logic             join_fire
);
  always_comb begin
    // R1: a joined valid means every lane sees exactly downstream ready
    if (out_valid) begin
      a_r1_valid_all_ready : assert (in_ready == {LANES{out_ready}})
        else $error("R1 joined valid with uneven ready");
    end
    // R2: a ready lane implies downstream ready and at most one lane invalid
    if (in_ready != '0) begin
      a_r2_ready_needs_others : assert (out_ready && ($countones(in_valid) + 1 >= LANES))
        else $error("R2 ready without others valid");
    end
    // R4: no ready without downstream ready
    if (!out_ready) begin
      a_r4_no_ready_when_blocked : assert (in_ready == '0)
        else $error("R4 ready leaked");
    end
    // R6: two invalid lanes block everything
    if ($countones(in_valid) + 2 <= LANES) begin
      a_r6_two_idle_block : assert (in_ready == '0)
        else $error("R6 ready with two idle lanes");
    end
    // R5: every lane fires with the join
    for (int i = 0; i < LANES; i++) begin
      a_r5_lane_fire_matches : assert (lane_fire[i] == join_fire)
        else $error("R5 lane fire out of step");
    end
  end
endmodule

bind lockstep_join lsj_checker #(.LANES(LANES)) u_lsj_chk (
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .lane_fire (lane_fire),
  .join_fire (join_fire)
);

// File: tb/lockstep_join_tb_top.sv
`timescale 1ns/1ps
module lockstep_join_tb_top;
  localparam int LANES = 6;
  localparam int WIDTH = 8;
  localparam int TOTAL = LANES * WIDTH;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [TOTAL-1:0] in_data;
  logic [LANES-1:0] in_valid;
  logic             out_ready;
  logic [LANES-1:0] rdy_flat, rdy_tree;
  logic [TOTAL-1:0] dat_flat, dat_tree;
  logic             vld_flat, vld_tree;

  int compared   = 0;
  int mismatched = 0;
  logic [7:0] lane_cnt [LANES];

  lockstep_join #(.LANES(LANES), .WIDTH(WIDTH), .GROUP(0)) dut_i (
    .in_data(in_data), .in_valid(in_valid), .in_ready(rdy_flat),
    .out_data(dat_flat), .out_valid(vld_flat), .out_ready(out_ready));

  lockstep_join #(.LANES(LANES), .WIDTH(WIDTH), .GROUP(3)) dut_tree_i (
    .in_data(in_data), .in_valid(in_valid), .in_ready(rdy_tree),
    .out_data(dat_tree), .out_valid(vld_tree), .out_ready(out_ready));

  function automatic logic model_valid(input logic [LANES-1:0] v);
    for (int i = 0; i < LANES; i++) if (!v[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [LANES-1:0] model_ready(input logic [LANES-1:0] v, input logic r);
    logic [LANES-1:0] res;
    for (int i = 0; i < LANES; i++) begin
      int idle = 0;
      for (int j = 0; j < LANES; j++) if (j != i && !v[j]) idle++;
      res[i] = r && (idle == 0);
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_data();
    for (int i = 0; i < LANES; i++) in_data[i*WIDTH +: WIDTH] = lane_cnt[i];
  endtask

  // one cycle: apply, check at negedge, update counts at posedge
  task automatic step(input logic [LANES-1:0] v, input logic r);
    logic [LANES-1:0] er;
    logic ev;
    in_valid  = v;
    out_ready = r;
    drive_data();
    @(negedge clk);
    ev = model_valid(v);
    er = model_ready(v, r);
    check("R1 out_valid", {63'd0, vld_flat}, {63'd0, ev});
    check("R2 in_ready", {58'd0, rdy_flat}, {58'd0, er});
    if (!r) check("R4 blocked ready", {58'd0, rdy_flat}, 64'd0);
    if ($countones(v) + 2 <= LANES) check("R6 two idle", {58'd0, rdy_flat}, 64'd0);
    check("R3 out_data", {16'd0, dat_flat}, {16'd0, in_data});
    check("R7 tree ready", {58'd0, rdy_tree}, {58'd0, er});
    check("R7 tree valid", {63'd0, vld_tree}, {63'd0, ev});
    check("R7 tree data", {16'd0, dat_tree}, {16'd0, in_data});
    if (ev && r) begin
      for (int i = 1; i < LANES; i++)
        check("R5 ordered payload", {56'd0, dat_flat[i*WIDTH +: WIDTH]}, {56'd0, dat_flat[7:0]});
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < LANES; i++)
      if (in_valid[i] && rdy_flat[i]) lane_cnt[i] = lane_cnt[i] + 8'd1;
    for (int i = 1; i < LANES; i++)
      check("R5 equal counts", {56'd0, lane_cnt[i]}, {56'd0, lane_cnt[0]});
  endtask

  // random phase: a lane that offers a word holds it until it transfers
  task automatic random_phase(input int cycles, input int pct_valid, input int pct_ready);
    logic [LANES-1:0] v = '0;
    for (int c = 0; c < cycles; c++) begin
      logic [LANES-1:0] nv;
      logic fired;
      for (int i = 0; i < LANES; i++)
        nv[i] = v[i] ? 1'b1 : (($urandom % 100) < pct_valid);
      step(nv, ($urandom % 100) < pct_ready);
      fired = model_valid(nv) && out_ready;
      v = fired ? '0 : nv;
    end
  endtask

  bit done = 0;

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < LANES; i++) lane_cnt[i] = 8'd0;
    in_valid = '0; out_ready = 1'b0; drive_data();
    @(posedge clk); #1;
    // reset-like idle state
    step('0, 1'b0);
    // directed corners
    step('1, 1'b0);               // R4 all valid, blocked
    step(6'b111011, 1'b1);        // R2 only lane 2 sees ready
    step(6'b110011, 1'b1);        // R6 two idle lanes
    step('1, 1'b1);               // R1/R5 full fire
    step(6'b011111, 1'b1);        // R2 lane 5 idle
    step('1, 1'b1);
    random_phase(3000, 85, 70);   // dense
    random_phase(3000, 30, 90);   // sparse
    random_phase(2000, 60, 40);   // mixed
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule